// File: doc/BRIEF.md
# Eye Scan Error Accumulator

This block measures how often an auxiliary receiver sampler disagrees with the live data sampler. It steps that auxiliary sampler across a two-dimensional grid of offsets. Each clock it receives two deserialized words of equal width on the same recovered clock. The first is the data word. The second is the offset word, taken with a phase shift and a threshold shift that this block drives.

For each grid point the block counts the bits it examined and the bits that differed. It ends the point when either count reaches its programmed limit. It then reports both counts together with the offset codes they belong to. Software forms the error ratio from the count pair.

The data word passes straight through and is never touched, so a scan can run while live traffic is received. A settling window after every offset change discards words taken while the sampler moves. A lane mask restricts the count to selected bit positions.

Top module: `eye_scan_accum`

## Requirements
- R1: `data_out` equals `data_word` at all times, whether idle, settling or counting.
- R2: In each counted cycle the sample count grows by the number of set bits in `lane_mask`. The error count grows by the number of set bits in `(data_word ^ offs_word) & lane_mask`. Bit i of the mask enables bit position i.
- R3: After every offset change (scan start and each new point), the words of the next `settle_cycles`+1 clocks are discarded. `h_offset`/`v_offset` stay constant while a point is counted.
- R4: A point ends on the first counted word after which the sample count is at least `sample_limit` or the error count is at least `error_limit`. `pt_valid` pulses for one cycle at that edge. `pt_samples`, `pt_errors`, `pt_h` and `pt_v` then hold that point's totals, including the final word, until the next point ends.
- R5: Offsets are two's complement. The vertical offset is the inner loop: it runs from `v_start` in steps of `v_step` while not above `v_end`. The horizontal offset is the outer loop and runs the same way from `h_start` to `h_end`.
- R6: Both counters saturate at all ones instead of wrapping, and a saturated error count still ends the point when it meets `error_limit`.
- R7: `done` rises in the same cycle as the last point's `pt_valid`. At that cycle `busy` falls and both offsets return to zero. `done` stays high until the next accepted `start` or an `abort`.
- R8: `start` is ignored while `busy` is high, so the sweep order and counts continue unchanged.
- R9: A synchronous `abort` returns the block to idle in the next cycle, with offsets at zero and `done` low. No further `pt_valid` follows.
- R10: After reset the block is idle, with offsets zero, `done` and `pt_valid` low, and the reported counts zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a sweep when idle |
| abort | input | 1 | Synchronous return to idle |
| h_start | input | OW | First horizontal offset, signed |
| h_end | input | OW | Last allowed horizontal offset, signed |
| h_step | input | OW | Horizontal increment |
| v_start | input | OW | First vertical offset, signed |
| v_end | input | OW | Last allowed vertical offset, signed |
| v_step | input | OW | Vertical increment |
| settle_cycles | input | SETW | Extra discarded cycles after an offset change |
| sample_limit | input | CW | Sample count that ends a point |
| error_limit | input | EW | Error count that ends a point |
| lane_mask | input | W | Bit positions included in counting |
| data_word | input | W | Data-sampler word |
| offs_word | input | W | Offset-sampler word |
| data_out | output | W | Unmodified data word |
| h_offset | output | OW | Phase offset code to the offset sampler |
| v_offset | output | OW | Threshold offset code to the offset sampler |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished |
| pt_valid | output | 1 | One-cycle strobe for a finished point |
| pt_samples | output | CW | Sample count of the last point |
| pt_errors | output | EW | Error count of the last point |
| pt_h | output | OW | Horizontal offset of the last point |
| pt_v | output | OW | Vertical offset of the last point |

## Verification
A wrong settle counter shifts which words are counted. With error-laden words fed only during settling, that appears as nonzero `pt_errors` on the first reported point. A broken loop step or wrap shows as a wrong `pt_h`/`pt_v` at the very next `pt_valid`. Accumulator faults, missing saturation or an off-by-one limit compare show in `pt_samples`/`pt_errors` at the end of the affected point, or as a point that never ends. Control faults such as a restart on `start` or an incomplete `abort` appear within one cycle on `busy` and the offset codes, or as a repeated grid point.

// File: rtl/es_pkg.sv
package es_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_COUNT  = 2'd2
    } es_state_e;
endpackage

// File: rtl/es_popcount.sv
module es_popcount #(
    parameter int W  = 32,
    parameter int PW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits,
    output logic [PW-1:0] ones
);
    logic [PW-1:0] sum_d;

    always_comb begin
        sum_d = '0;
        for (int i = 0; i < W; i++) begin
            sum_d = sum_d + PW'(bits[i]);
        end
    end

    assign ones = sum_d;
endmodule

// File: rtl/es_point_acc.sv
module es_point_acc #(
    parameter int PW = 6,
    parameter int CW = 48,
    parameter int EW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] samp_inc,
    input  logic [PW-1:0] err_inc,
    input  logic [CW-1:0] sample_limit,
    input  logic [EW-1:0] error_limit,
    output logic          hit,
    output logic [CW-1:0] samp_nx,
    output logic [EW-1:0] err_nx
);
    typedef struct packed {
        logic [CW-1:0] samples;
        logic [EW-1:0] errors;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [CW:0] s_sum;
    logic [EW:0] e_sum;

    always_comb begin
        s_sum   = {1'b0, acc_q.samples} + (CW + 1)'(samp_inc);
        e_sum   = {1'b0, acc_q.errors} + (EW + 1)'(err_inc);
        samp_nx = s_sum[CW] ? {CW{1'b1}} : s_sum[CW-1:0];
        err_nx  = e_sum[EW] ? {EW{1'b1}} : e_sum[EW-1:0];
        hit     = en && ((samp_nx >= sample_limit) || (err_nx >= error_limit));
        acc_d   = acc_q;
        if (en) begin
            acc_d.samples = samp_nx;
            acc_d.errors  = err_nx;
        end else begin
            acc_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    // R6: counting never moves a counter backwards (no wrap)
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (acc_q.errors >= $past(acc_q.errors)) &&
               (acc_q.samples >= $past(acc_q.samples)));
endmodule

// File: rtl/es_sweep_ctrl.sv
module es_sweep_ctrl
    import es_pkg::*;
#(
    parameter int OW   = 6,
    parameter int SETW = 8,
    parameter int CW   = 48,
    parameter int EW   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 abort,
    input  logic signed [OW-1:0] h_start,
    input  logic signed [OW-1:0] h_end,
    input  logic signed [OW-1:0] h_step,
    input  logic signed [OW-1:0] v_start,
    input  logic signed [OW-1:0] v_end,
    input  logic signed [OW-1:0] v_step,
    input  logic [SETW-1:0]      settle_cycles,
    input  logic                 hit,
    input  logic [CW-1:0]        samp_nx,
    input  logic [EW-1:0]        err_nx,
    output logic                 count_en,
    output logic signed [OW-1:0] h_off,
    output logic signed [OW-1:0] v_off,
    output logic                 busy,
    output logic                 done,
    output logic                 pt_valid,
    output logic [CW-1:0]        pt_samples,
    output logic [EW-1:0]        pt_errors,
    output logic signed [OW-1:0] pt_h,
    output logic signed [OW-1:0] pt_v
);
    typedef struct packed {
        es_state_e      state;
        logic [OW-1:0]  h;
        logic [OW-1:0]  v;
        logic [SETW-1:0] settle;
        logic           done;
        logic           pt_valid;
        logic [CW-1:0]  pt_samples;
        logic [EW-1:0]  pt_errors;
        logic [OW-1:0]  pt_h;
        logic [OW-1:0]  pt_v;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic [OW:0] h_nx, v_nx;
    logic        h_past, v_past;

    always_comb begin
        h_nx   = {c_q.h[OW-1], c_q.h} + {h_step[OW-1], h_step};
        v_nx   = {c_q.v[OW-1], c_q.v} + {v_step[OW-1], v_step};
        h_past = $signed(h_nx) > $signed({h_end[OW-1], h_end});
        v_past = $signed(v_nx) > $signed({v_end[OW-1], v_end});

        c_d          = c_q;
        c_d.pt_valid = 1'b0;

        unique case (c_q.state)
            ST_IDLE: begin
                if (start) begin
                    c_d.state  = ST_SETTLE;
                    c_d.h      = h_start;
                    c_d.v      = v_start;
                    c_d.settle = '0;
                    c_d.done   = 1'b0;
                end
            end
            ST_SETTLE: begin
                if (c_q.settle == settle_cycles) c_d.state  = ST_COUNT;
                else                             c_d.settle = c_q.settle + 1'b1;
            end
            ST_COUNT: begin
                if (hit) begin
                    c_d.pt_valid   = 1'b1;
                    c_d.pt_samples = samp_nx;
                    c_d.pt_errors  = err_nx;
                    c_d.pt_h       = c_q.h;
                    c_d.pt_v       = c_q.v;
                    c_d.settle     = '0;
                    if (!v_past) begin
                        c_d.v     = v_nx[OW-1:0];
                        c_d.state = ST_SETTLE;
                    end else if (!h_past) begin
                        c_d.v     = v_start;
                        c_d.h     = h_nx[OW-1:0];
                        c_d.state = ST_SETTLE;
                    end else begin
                        c_d.h     = '0;
                        c_d.v     = '0;
                        c_d.done  = 1'b1;
                        c_d.state = ST_IDLE;
                    end
                end
            end
            default: c_d.state = ST_IDLE;
        endcase

        if (abort) begin
            c_d.state    = ST_IDLE;
            c_d.h        = '0;
            c_d.v        = '0;
            c_d.settle   = '0;
            c_d.done     = 1'b0;
            c_d.pt_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign count_en   = (c_q.state == ST_COUNT);
    assign busy       = (c_q.state != ST_IDLE);
    assign done       = c_q.done;
    assign h_off      = c_q.h;
    assign v_off      = c_q.v;
    assign pt_valid   = c_q.pt_valid;
    assign pt_samples = c_q.pt_samples;
    assign pt_errors  = c_q.pt_errors;
    assign pt_h       = c_q.pt_h;
    assign pt_v       = c_q.pt_v;

    // R4: the per-point strobe lasts exactly one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pt_valid |=> !pt_valid);

    // R3: offsets are frozen while a point is still being counted
    p_hold_offsets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && !hit && !abort) |=> ($stable(h_off) && $stable(v_off)));

    // R9: abort lands in idle with zeroed offsets
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !done && h_off == '0 && v_off == '0));

    // R7: a finished sweep is never still busy
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: rtl/eye_scan_accum.sv
module eye_scan_accum #(
    parameter int W    = 32,
    parameter int CW   = 48,
    parameter int EW   = 32,
    parameter int OW   = 6,
    parameter int SETW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 abort,
    input  logic signed [OW-1:0] h_start,
    input  logic signed [OW-1:0] h_end,
    input  logic signed [OW-1:0] h_step,
    input  logic signed [OW-1:0] v_start,
    input  logic signed [OW-1:0] v_end,
    input  logic signed [OW-1:0] v_step,
    input  logic [SETW-1:0]      settle_cycles,
    input  logic [CW-1:0]        sample_limit,
    input  logic [EW-1:0]        error_limit,
    input  logic [W-1:0]         lane_mask,
    input  logic [W-1:0]         data_word,
    input  logic [W-1:0]         offs_word,
    output logic [W-1:0]         data_out,
    output logic signed [OW-1:0] h_offset,
    output logic signed [OW-1:0] v_offset,
    output logic                 busy,
    output logic                 done,
    output logic                 pt_valid,
    output logic [CW-1:0]        pt_samples,
    output logic [EW-1:0]        pt_errors,
    output logic signed [OW-1:0] pt_h,
    output logic signed [OW-1:0] pt_v
);
    localparam int PW = $clog2(W + 1);

    logic [W-1:0]  miss_bits;
    logic [PW-1:0] samp_inc, err_inc;
    logic          count_en, hit;
    logic [CW-1:0] samp_nx;
    logic [EW-1:0] err_nx;

    assign data_out  = data_word;
    assign miss_bits = (data_word ^ offs_word) & lane_mask;

    es_popcount #(.W(W), .PW(PW)) u_pop_samp (.bits(lane_mask), .ones(samp_inc));
    es_popcount #(.W(W), .PW(PW)) u_pop_err  (.bits(miss_bits), .ones(err_inc));

    es_point_acc #(.PW(PW), .CW(CW), .EW(EW)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (count_en),
        .samp_inc     (samp_inc),
        .err_inc      (err_inc),
        .sample_limit (sample_limit),
        .error_limit  (error_limit),
        .hit          (hit),
        .samp_nx      (samp_nx),
        .err_nx       (err_nx)
    );

    es_sweep_ctrl #(.OW(OW), .SETW(SETW), .CW(CW), .EW(EW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .abort         (abort),
        .h_start       (h_start),
        .h_end         (h_end),
        .h_step        (h_step),
        .v_start       (v_start),
        .v_end         (v_end),
        .v_step        (v_step),
        .settle_cycles (settle_cycles),
        .hit           (hit),
        .samp_nx       (samp_nx),
        .err_nx        (err_nx),
        .count_en      (count_en),
        .h_off         (h_offset),
        .v_off         (v_offset),
        .busy          (busy),
        .done          (done),
        .pt_valid      (pt_valid),
        .pt_samples    (pt_samples),
        .pt_errors     (pt_errors),
        .pt_h          (pt_h),
        .pt_v          (pt_v)
    );
endmodule

// File: tb/eye_scan_accum_test.sv
module eye_scan_accum_test;
    localparam int W    = 16;
    localparam int CW   = 48;
    localparam int EW   = 10;
    localparam int OW   = 6;
    localparam int SETW = 8;
    localparam int EMAX = (1 << EW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic abort = 1'b0;
    logic signed [OW-1:0] h_start = '0, h_end = '0, h_step = 1, v_start = '0, v_end = '0, v_step = 1;
    logic [SETW-1:0] settle_cycles = '0;
    logic [CW-1:0]   sample_limit = 100;
    logic [EW-1:0]   error_limit = 10;
    logic [W-1:0]    lane_mask = '1;
    logic [W-1:0]    data_word = '0, offs_word = '0;
    logic [W-1:0]    data_out;
    logic signed [OW-1:0] h_offset, v_offset, pt_h, pt_v;
    logic busy, done, pt_valid;
    logic [CW-1:0] pt_samples;
    logic [EW-1:0] pt_errors;

    int n_chk = 0;
    int n_fail = 0;
    int mode = 0;   // 0: per-offset pattern, 1: every bit wrong, 2: clean

    eye_scan_accum #(.W(W), .CW(CW), .EW(EW), .OW(OW), .SETW(SETW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .h_start(h_start), .h_end(h_end), .h_step(h_step),
        .v_start(v_start), .v_end(v_end), .v_step(v_step),
        .settle_cycles(settle_cycles), .sample_limit(sample_limit),
        .error_limit(error_limit), .lane_mask(lane_mask),
        .data_word(data_word), .offs_word(offs_word), .data_out(data_out),
        .h_offset(h_offset), .v_offset(v_offset), .busy(busy), .done(done),
        .pt_valid(pt_valid), .pt_samples(pt_samples), .pt_errors(pt_errors),
        .pt_h(pt_h), .pt_v(pt_v)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pop16(input logic [15:0] x);
        int n = 0;
        for (int i = 0; i < 16; i++) n += int'(x[i]);
        return n;
    endfunction

    function automatic logic [15:0] errword(input int h, input int v);
        int sel = ((h + 40) * 3 + (v + 40)) % 6;
        int r = (v + 40) % 16;
        int n;
        logic [31:0] m;
        logic [15:0] m16;
        case (sel)
            0: n = 0;
            1: n = 1;
            2: n = 2;
            3: n = 3;
            4: n = 8;
            default: n = 16;
        endcase
        m = (n == 16) ? 32'hFFFF : ((32'd1 << n) - 1);
        m16 = m[15:0];
        return (m16 << r) | (m16 >> (16 - r));
    endfunction

    task automatic expect_point(input logic [15:0] msk, input logic [15:0] ew,
                                input longint sl, input longint el,
                                output longint s, output longint e);
        longint m = pop16(msk);
        longint ee = pop16(ew & msk);
        s = 0;
        e = 0;
        for (int k = 0; k < 100000; k++) begin
            s += m;
            e += ee;
            if (e > EMAX) e = EMAX;
            if (s >= sl || e >= el) break;
        end
    endtask

    // word driver: a little after each falling edge
    initial begin
        void'($urandom(32'd20240611));
        forever begin
            logic [W-1:0] d;
            @(negedge clk);
            #1;
            d = W'($urandom);
            data_word = d;
            case (mode)
                1: offs_word = ~d;
                2: offs_word = d;
                default: offs_word = d ^ errword(int'(h_offset), int'(v_offset));
            endcase
        end
    end

    task automatic wait_pt(output bit got);
        got = 0;
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk);
            if (t % 11 == 3) check("R1 data pass-through", longint'(data_out), longint'(data_word));
            if (pt_valid) begin
                got = 1;
                break;
            end
        end
        if (!got) check("R4 point never finished", 0, 1);
    endtask

    task automatic run_scan(input int hs, input int he, input int hst,
                            input int vs, input int ve, input int vst,
                            input int st, input logic [15:0] msk,
                            input longint sl, input longint el, input bit poke);
        int total = 0;
        int idx = 0;
        bit got;
        longint es, ee;
        for (int h = hs; h <= he; h += hst)
            for (int v = vs; v <= ve; v += vst) total++;
        @(negedge clk);
        h_start = OW'(hs); h_end = OW'(he); h_step = OW'(hst);
        v_start = OW'(vs); v_end = OW'(ve); v_step = OW'(vst);
        settle_cycles = SETW'(st); lane_mask = msk;
        sample_limit = CW'(sl); error_limit = EW'(el);
        mode = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        check("R7 done cleared by start", longint'(done), 0);
        check("R7 busy after start", longint'(busy), 1);
        for (int h = hs; h <= he; h += hst) begin
            for (int v = vs; v <= ve; v += vst) begin
                wait_pt(got);
                if (!got) return;
                idx++;
                expect_point(msk, errword(h, v), sl, el, es, ee);
                check("R5 point h order", longint'(pt_h), h);
                check("R5 point v order", longint'(pt_v), v);
                check("R2/R4 point samples", longint'(pt_samples), es);
                check("R2/R4 point errors", longint'(pt_errors), ee);
                if (idx == total) begin
                    check("R7 done with last point", longint'(done), 1);
                    check("R7 idle after last point", longint'(busy), 0);
                    check("R7 offsets zero at end", longint'(h_offset) + longint'(v_offset), 0);
                end else if (poke && idx == 1) begin
                    start = 1;   // R8: must be ignored while busy
                    @(negedge clk);
                    start = 0;
                end
            end
        end
        repeat (3) @(negedge clk);
        check("R7 done holds", longint'(done), 1);
    endtask

    initial begin
        bit got;
        // watchdog
        fork
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected finish");
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        join_none

        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        check("R10 busy", longint'(busy), 0);
        check("R10 done", longint'(done), 0);
        check("R10 h_offset", longint'(h_offset), 0);
        check("R10 v_offset", longint'(v_offset), 0);
        check("R10 pt_valid", longint'(pt_valid), 0);
        check("R10 pt_samples", longint'(pt_samples), 0);
        check("R1 pass-through idle", longint'(data_out), longint'(data_word));

        // R3 settle window: errored words only while settling
        h_start = 3; h_end = 3; h_step = 1; v_start = -2; v_end = -2; v_step = 1;
        settle_cycles = 5; lane_mask = '1; sample_limit = 160; error_limit = 1023;
        mode = 1;
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (6) @(negedge clk);
        mode = 2;
        check("R3 h offset during point", longint'(h_offset), 3);
        check("R3 v offset during point", longint'(v_offset), -2);
        wait_pt(got);
        check("R3 settle words discarded", longint'(pt_errors), 0);
        check("R3 samples after settle", longint'(pt_samples), 160);

        // R6 saturation of the error counter
        @(negedge clk);
        h_start = 0; h_end = 0; v_start = 0; v_end = 0;
        settle_cycles = 0; sample_limit = 100000; error_limit = EW'(EMAX);
        mode = 1;
        start = 1;
        @(negedge clk);
        start = 0;
        wait_pt(got);
        check("R6 errors saturate", longint'(pt_errors), EMAX);
        check("R6 samples at saturation", longint'(pt_samples), 1024);
        check("R2 lane count full mask", longint'(pt_samples) % 16, 0);

        // directed: error limit of one ends on first erroring word, narrow mask
        run_scan(-1, -1, 1, 0, 4, 2, 0, 16'h00F0, 200, 1, 0);

        // random sweeps, first one pokes start while busy (R8)
        for (int s = 0; s < 4; s++) begin
            int hs = int'($urandom_range(0, 10)) - 5;
            int hst = int'($urandom_range(1, 3));
            int he = hs + int'($urandom_range(0, 4));
            int vs = int'($urandom_range(0, 12)) - 6;
            int vst = int'($urandom_range(1, 3));
            int ve = (s == 0) ? vs + 2 * vst : vs + int'($urandom_range(0, 6));
            int st = int'($urandom_range(0, 4));
            logic [15:0] msk = 16'($urandom) | 16'h0001;
            longint sl = longint'($urandom_range(20, 300));
            longint el = ($urandom_range(0, 1) == 1) ? longint'($urandom_range(1, 60)) : 1023;
            run_scan(hs, he, hst, vs, ve, vst, st, msk, sl, el, s == 0);
        end

        // R9 abort mid-point
        @(negedge clk);
        h_start = 1; h_end = 4; v_start = 0; v_end = 5;
        settle_cycles = 0; sample_limit = 5000; error_limit = 1023; mode = 2;
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (10) @(negedge clk);
        abort = 1;
        @(negedge clk);
        abort = 0;
        check("R9 idle after abort", longint'(busy), 0);
        check("R9 h zero after abort", longint'(h_offset), 0);
        check("R9 v zero after abort", longint'(v_offset), 0);
        check("R9 done low after abort", longint'(done), 0);
        begin
            int seen = 0;
            for (int t = 0; t < 400; t++) begin
                @(negedge clk);
                if (pt_valid) seen++;
            end
            check("R9 no point after abort", seen, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule